// File: doc/BRIEF.md
# Accumulator ALU with Iterative Multiply and Divide

This block is a fixed-point arithmetic unit organised around three one-word registers. The accumulator holds the running result. The data register holds the second operand. The multiplier-quotient register extends the accumulator into a double-width pair. One-cycle operations combine the accumulator with the data register and write the result back into the accumulator. Shifts move the accumulator and multiplier-quotient pair as one unit. Unsigned multiply and divide run as iterative shift-and-add and shift-and-subtract sequences across that pair.

Software or a sequencer loads operands through the data and multiplier-quotient load ports while the unit is idle. It then issues an opcode with a one-cycle start strobe and waits for the done pulse. The accumulator can only be set through the operations themselves. An AND with a zero data register clears it, and an ADD then places any value in it. Four status flags (zero, carry, overflow, negative) describe the last completed operation.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator, multiplier-quotient and data registers are zero, all four flags are zero, and busy and done are low.
- R2: While the unit is idle and no start is given, dr_load writes dr_wdata into the data register and mq_load writes mq_wdata into the multiplier-quotient register at the clock edge. Both loads are ignored while busy is high.
- R3: Opcode 0 (ADD) sets AC to AC+DR modulo 2^W. C is the carry out of the top bit. V is set when both operands share a sign and the result sign differs. Z is set when the new AC is zero, and N is the MSB of the new AC.
- R4: Opcode 1 (SUB) sets AC to AC-DR in two's complement. C is 1 exactly when no borrow occurs (AC >= DR unsigned). V is set when the operand signs differ and the result sign differs from AC. Z and N come from the new AC.
- R5: Opcodes 2 (AND), 3 (OR) and 4 (XOR) combine AC with DR bitwise, and opcode 5 (NOT) inverts AC. All four clear C and V, set Z and N from the new AC, and leave MQ unchanged.
- R6: Opcode 6 shifts the pair {AC,MQ} left by one bit with zero fill, and opcode 7 shifts it right by one bit with zero fill. C takes the bit shifted out, V is cleared, and Z and N come from the new AC.
- R7: Every operation other than an iterative multiply or divide completes at the clock edge that samples start. Done is high in the following cycle, and busy stays low.
- R8: Opcode 8 (MUL) leaves the unsigned product DR×MQ in {AC,MQ}, with the upper half in AC. Busy is high for exactly W cycles, and the result and done appear W clock edges after the edge that samples start. Z is set when the whole product is zero, and C, V and N are cleared.
- R9: Opcode 9 (DIV) with a nonzero DR leaves the quotient MQ÷DR in MQ and the remainder in AC, with the same W-edge timing as R8. Z is set when the quotient is zero, and C, V and N are cleared.
- R10: DIV with DR equal to zero completes in one cycle. It sets V, clears Z, C and N, and leaves AC and MQ unchanged.
- R11: Busy and done are never high together. Done is high in the cycle after busy falls. A start given while busy has no effect on the running operation or on its result.
- R12: Opcodes 10 to 15 change no register or flag, but still produce a done pulse in the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that launches the operation on opcode |
| opcode | input | 4 | Operation select (encodings in R3 to R12) |
| dr_load | input | 1 | Write dr_wdata into the data register |
| dr_wdata | input | W | Data register load value |
| mq_load | input | 1 | Write mq_wdata into the multiplier-quotient register |
| mq_wdata | input | W | Multiplier-quotient load value |
| busy | output | 1 | Iterative operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ac_out | output | W | Accumulator contents |
| mq_out | output | W | Multiplier-quotient contents |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_n | output | 1 | Negative flag |

## Verification
Each result is due at one of two cycles. Single-cycle operations, divide by zero and unused opcodes update AC, MQ, the flags and done at the edge that samples start. Multiply and divide deliver their result and done exactly W edges later. The bench raises start at a falling edge and drops it at the next falling edge. It then counts falling edges until done is seen and checks that count against zero or W before it compares any register. All sampling happens at falling edges, half a period away from the edge that updates the outputs.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_SUB = 4'd1;
  localparam logic [3:0] OP_AND = 4'd2;
  localparam logic [3:0] OP_OR  = 4'd3;
  localparam logic [3:0] OP_XOR = 4'd4;
  localparam logic [3:0] OP_NOT = 4'd5;
  localparam logic [3:0] OP_SHL = 4'd6;
  localparam logic [3:0] OP_SHR = 4'd7;
  localparam logic [3:0] OP_MUL = 4'd8;
  localparam logic [3:0] OP_DIV = 4'd9;

  typedef struct packed {
    logic z;
    logic c;
    logic v;
    logic n;
  } flags_t;

endpackage

// File: rtl/acc_alu_logic.sv
// Single-cycle datapath: next AC, MQ and flags for every non-iterative opcode.
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] mq,
  input  logic [W-1:0] dr,
  input  flags_t       flags_in,
  output logic [W-1:0] ac_nx,
  output logic [W-1:0] mq_nx,
  output flags_t       flags_nx
);

  // Returns {overflow, carry, result}; sub adds the inverted operand plus one.
  function automatic logic [W+1:0] addsub(input logic [W-1:0] a,
                                          input logic [W-1:0] b,
                                          input logic sub);
    logic [W-1:0] bb;
    logic [W:0]   s;
    logic         ov;
    bb = sub ? ~b : b;
    s  = {1'b0, a} + {1'b0, bb} + {{W{1'b0}}, sub};
    ov = (a[W-1] == bb[W-1]) && (s[W-1] != a[W-1]);
    return {ov, s};
  endfunction

  logic [W+1:0] as_res;
  logic         upd;

  always_comb begin
    as_res   = addsub(ac, dr, op == OP_SUB);
    ac_nx    = ac;
    mq_nx    = mq;
    flags_nx = flags_in;
    upd      = 1'b1;
    case (op)
      OP_ADD, OP_SUB: begin
        ac_nx      = as_res[W-1:0];
        flags_nx.c = as_res[W];
        flags_nx.v = as_res[W+1];
      end
      OP_AND, OP_OR, OP_XOR, OP_NOT: begin
        case (op)
          OP_AND:  ac_nx = ac & dr;
          OP_OR:   ac_nx = ac | dr;
          OP_XOR:  ac_nx = ac ^ dr;
          default: ac_nx = ~ac;
        endcase
        flags_nx.c = 1'b0;
        flags_nx.v = 1'b0;
      end
      OP_SHL: begin
        {flags_nx.c, ac_nx, mq_nx} = {ac, mq, 1'b0};
        flags_nx.v = 1'b0;
      end
      OP_SHR: begin
        {ac_nx, mq_nx} = {1'b0, ac, mq[W-1:1]};
        flags_nx.c = mq[0];
        flags_nx.v = 1'b0;
      end
      OP_DIV: begin
        // Only a zero divisor brings DIV down the single-cycle path.
        flags_nx = '{z: 1'b0, c: 1'b0, v: 1'b1, n: 1'b0};
        upd      = 1'b0;
      end
      default: upd = 1'b0;
    endcase
    if (upd) begin
      flags_nx.z = (ac_nx == '0);
      flags_nx.n = ac_nx[W-1];
    end
  end

endmodule

// File: rtl/acc_alu_step.sv
// One iteration of shift-add multiply or restoring divide on {AC,MQ}.
module acc_alu_step #(
  parameter int W = 8
) (
  input  logic         is_div,
  input  logic [W-1:0] ac,
  input  logic [W-1:0] mq,
  input  logic [W-1:0] dr,
  output logic [W-1:0] ac_nx,
  output logic [W-1:0] mq_nx
);

  function automatic logic [2*W-1:0] mul_step(input logic [W-1:0] a,
                                              input logic [W-1:0] q,
                                              input logic [W-1:0] d);
    logic [W:0] s;
    s = {1'b0, a} + (q[0] ? {1'b0, d} : '0);
    return {s, q[W-1:1]};
  endfunction

  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] a,
                                              input logic [W-1:0] q,
                                              input logic [W-1:0] d);
    logic [W:0] rem;
    logic [W:0] diff;
    rem  = {a, q[W-1]};
    diff = rem - {1'b0, d};
    if (rem >= {1'b0, d}) return {diff[W-1:0], q[W-2:0], 1'b1};
    else                  return {rem[W-1:0],  q[W-2:0], 1'b0};
  endfunction

  always_comb begin
    if (is_div) {ac_nx, mq_nx} = div_step(ac, mq, dr);
    else        {ac_nx, mq_nx} = mul_step(ac, mq, dr);
  end

endmodule

// File: rtl/acc_alu_ctrl.sv
// Launch decode, iteration counter, busy and done.
module acc_alu_ctrl
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [3:0] op,
  input  logic       dr_zero,
  output logic       busy,
  output logic       done,
  output logic       go_single,
  output logic       go_iter,
  output logic       last_step,
  output logic       mode_div
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic          accept;
  logic          iter_op;

  assign accept    = start && !busy;
  assign iter_op   = (op == OP_MUL) || ((op == OP_DIV) && !dr_zero);
  assign go_iter   = accept && iter_op;
  assign go_single = accept && !iter_op;
  assign last_step = busy && (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      cnt      <= '0;
      mode_div <= 1'b0;
    end else begin
      done <= go_single || last_step;
      if (go_iter) begin
        busy     <= 1'b1;
        cnt      <= CW'(W);
        mode_div <= (op == OP_DIV);
      end else if (busy) begin
        cnt <= cnt - CW'(1);
        if (last_step) busy <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [3:0]   opcode,
  input  logic         dr_load,
  input  logic [W-1:0] dr_wdata,
  input  logic         mq_load,
  input  logic [W-1:0] mq_wdata,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] ac_out,
  output logic [W-1:0] mq_out,
  output logic         flag_z,
  output logic         flag_c,
  output logic         flag_v,
  output logic         flag_n
);

  logic [W-1:0] ac_q, mq_q, dr_q;
  flags_t       flags_q;

  // Named internal events, also visible to the bound checker.
  logic         go_single, go_iter, last_step, mode_div;
  logic         load_ok;
  logic [W-1:0] lg_ac, lg_mq, st_ac, st_mq;
  flags_t       lg_flags;
  logic         fin_z;

  acc_alu_ctrl #(.W(W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .op        (opcode),
    .dr_zero   (dr_q == '0),
    .busy      (busy),
    .done      (done),
    .go_single (go_single),
    .go_iter   (go_iter),
    .last_step (last_step),
    .mode_div  (mode_div)
  );

  acc_alu_logic #(.W(W)) u_logic (
    .op       (opcode),
    .ac       (ac_q),
    .mq       (mq_q),
    .dr       (dr_q),
    .flags_in (flags_q),
    .ac_nx    (lg_ac),
    .mq_nx    (lg_mq),
    .flags_nx (lg_flags)
  );

  acc_alu_step #(.W(W)) u_step (
    .is_div (mode_div),
    .ac     (ac_q),
    .mq     (mq_q),
    .dr     (dr_q),
    .ac_nx  (st_ac),
    .mq_nx  (st_mq)
  );

  assign load_ok = !busy && !start;
  assign fin_z   = mode_div ? (st_mq == '0) : ({st_ac, st_mq} == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ac_q    <= '0;
      mq_q    <= '0;
      flags_q <= '0;
    end else if (go_single) begin
      ac_q    <= lg_ac;
      mq_q    <= lg_mq;
      flags_q <= lg_flags;
    end else if (go_iter) begin
      ac_q <= '0;
    end else if (busy) begin
      ac_q <= st_ac;
      mq_q <= st_mq;
      if (last_step) flags_q <= '{z: fin_z, c: 1'b0, v: 1'b0, n: 1'b0};
    end else if (mq_load && load_ok) begin
      mq_q <= mq_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  dr_q <= '0;
    else if (dr_load && load_ok) dr_q <= dr_wdata;
  end

  assign ac_out = ac_q;
  assign mq_out = mq_q;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;
  assign flag_n = flags_q.n;

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [3:0]   opcode,
  input logic         busy,
  input logic         done,
  input logic [W-1:0] ac_out,
  input logic [W-1:0] mq_out,
  input logic         flag_v,
  input logic [W-1:0] dr_q,
  input logic         go_iter,
  input logic         go_single
);

  localparam int DW = 2 * W;

  logic [W-1:0] cap_dr, cap_mq;
  logic         cap_div, cap_valid;
  logic [15:0]  run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_dr <= '0; cap_mq <= '0; cap_div <= 1'b0; cap_valid <= 1'b0; run_len <= '0;
    end else if (go_iter) begin
      cap_dr    <= dr_q;
      cap_mq    <= mq_out;
      cap_div   <= (opcode == OP_DIV);
      cap_valid <= 1'b1;
      run_len   <= '0;
    end else begin
      if (go_single) cap_valid <= 1'b0;
      if (busy) run_len <= run_len + 16'd1;
    end
  end

  p_done_not_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  p_busy_ends_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_len == 16'(W)));

  p_single_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    go_single |=> (done && !busy));

  p_add_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opcode == OP_ADD) |=> (ac_out == $past(ac_out) + $past(dr_q)));

  p_div_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && opcode == OP_DIV && dr_q == '0)
      |=> (flag_v && $stable(ac_out) && $stable(mq_out)));

  p_mul_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_valid && !cap_div) |-> ({ac_out, mq_out} == DW'(cap_dr) * DW'(cap_mq)));

  p_div_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_valid && cap_div) |-> (mq_out == cap_mq / cap_dr && ac_out == cap_mq % cap_dr));

endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .opcode    (opcode),
  .busy      (busy),
  .done      (done),
  .ac_out    (ac_out),
  .mq_out    (mq_out),
  .flag_v    (flag_v),
  .dr_q      (dr_q),
  .go_iter   (go_iter),
  .go_single (go_single)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  import acc_alu_pkg::*;

  localparam int W = 8;
  localparam int NV = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [3:0]   opcode = '0;
  logic         dr_load = 1'b0, mq_load = 1'b0;
  logic [W-1:0] dr_wdata = '0, mq_wdata = '0;
  logic         busy, done, flag_z, flag_c, flag_v, flag_n;
  logic [W-1:0] ac_out, mq_out;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  acc_alu #(.W(W)) u_acc_alu (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .dr_load(dr_load), .dr_wdata(dr_wdata), .mq_load(mq_load), .mq_wdata(mq_wdata),
    .busy(busy), .done(done), .ac_out(ac_out), .mq_out(mq_out),
    .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n)
  );

  // {op, ac_init, dr, mq_init, exp_ac, exp_mq, exp_flags{z,c,v,n}}
  localparam logic [47:0] VEC [NV] = '{
    {OP_ADD, 8'hD0, 8'hB0, 8'h00, 8'h80, 8'h00, 4'b0101},
    {OP_ADD, 8'h70, 8'h10, 8'h00, 8'h80, 8'h00, 4'b0011},
    {OP_ADD, 8'hFF, 8'h01, 8'h00, 8'h00, 8'h00, 4'b1100},
    {OP_SUB, 8'h05, 8'h07, 8'h00, 8'hFE, 8'h00, 4'b0001},
    {OP_SUB, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h00, 4'b0110},
    {OP_SUB, 8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 4'b1100},
    {OP_AND, 8'hF0, 8'h3C, 8'h11, 8'h30, 8'h11, 4'b0000},
    {OP_OR,  8'h0F, 8'h80, 8'h22, 8'h8F, 8'h22, 4'b0001},
    {OP_XOR, 8'hAA, 8'hAA, 8'h33, 8'h00, 8'h33, 4'b1000},
    {OP_NOT, 8'hFF, 8'h55, 8'h44, 8'h00, 8'h44, 4'b1000},
    {OP_SHL, 8'h81, 8'h00, 8'h80, 8'h03, 8'h00, 4'b0100},
    {OP_SHR, 8'h01, 8'h00, 8'h03, 8'h00, 8'h81, 4'b1100},
    {OP_MUL, 8'h12, 8'hFF, 8'hFF, 8'hFE, 8'h01, 4'b0000},
    {OP_MUL, 8'h12, 8'h00, 8'h5A, 8'h00, 8'h00, 4'b1000},
    {OP_MUL, 8'h12, 8'h0C, 8'h0B, 8'h00, 8'h84, 4'b0000},
    {OP_DIV, 8'h12, 8'h07, 8'h64, 8'h02, 8'h0E, 4'b0000},
    {OP_DIV, 8'h12, 8'hC8, 8'h64, 8'h64, 8'h00, 4'b1000},
    {OP_DIV, 8'h21, 8'h00, 8'h64, 8'h21, 8'h64, 4'b0010}
  };

  function automatic string req_of(input logic [3:0] o, input logic [7:0] d);
    case (o)
      OP_ADD: return "R3";
      OP_SUB: return "R4";
      OP_SHL, OP_SHR: return "R6";
      OP_MUL: return "R8";
      OP_DIV: return (d == 8'h00) ? "R10" : "R9";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic load_dr(input logic [W-1:0] v);
    @(negedge clk); dr_load = 1'b1; dr_wdata = v;
    @(negedge clk); dr_load = 1'b0;
  endtask

  task automatic load_mq(input logic [W-1:0] v);
    @(negedge clk); mq_load = 1'b1; mq_wdata = v;
    @(negedge clk); mq_load = 1'b0;
  endtask

  // Returns edges after the start edge until done is seen.
  task automatic run_op(input logic [3:0] o, output int n);
    @(negedge clk); start = 1'b1; opcode = o;
    @(negedge clk); start = 1'b0; n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic set_ac(input logic [W-1:0] v);
    int n;
    load_dr('0); run_op(OP_AND, n);
    load_dr(v);  run_op(OP_ADD, n);
  endtask

  function automatic logic [3:0] flags_now();
    return {flag_z, flag_c, flag_v, flag_n};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  logic [3:0]   v_op, v_fl, saved_fl;
  logic [W-1:0] v_ac, v_dr, v_mq, v_eac, v_emq;
  int           n, exp_n;
  string        tag;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({ac_out, mq_out} == '0, "R1 ac/mq", {ac_out, mq_out}, 0);
    check(flags_now() == 4'b0000, "R1 flags", flags_now(), 0);
    check(!busy && !done, "R1 busy/done", {busy, done}, 0);

    // R2 loads reach registers while idle
    load_mq(8'h5A);
    check(mq_out == 8'h5A, "R2 mq load", mq_out, 8'h5A);
    load_dr(8'h27); run_op(OP_ADD, n);
    check(ac_out == 8'h27, "R2 dr load via ADD", ac_out, 8'h27);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      {v_op, v_ac, v_dr, v_mq, v_eac, v_emq, v_fl} = VEC[i];
      tag = req_of(v_op, v_dr);
      set_ac(v_ac);
      load_dr(v_dr);
      load_mq(v_mq);
      run_op(v_op, n);
      exp_n = (v_op == OP_MUL || (v_op == OP_DIV && v_dr != 0)) ? W : 0;
      // R7 single-cycle timing, R8/R9 W-edge timing
      check(n == exp_n, {tag, " R7 done latency"}, n, exp_n);
      check(!busy, {tag, " busy low at done"}, busy, 0);
      check(ac_out == v_eac, {tag, " ac"}, ac_out, v_eac);
      check(mq_out == v_emq, {tag, " mq"}, mq_out, v_emq);
      check(flags_now() == v_fl, {tag, " flags"}, flags_now(), v_fl);
    end

    // R12 undefined opcode: nothing changes, done still pulses
    saved_fl = flags_now();
    run_op(4'hC, n);
    check(n == 0, "R12 done pulse", n, 0);
    check(ac_out == 8'h21 && mq_out == 8'h64, "R12 regs kept", {ac_out, mq_out}, 16'h2164);
    check(flags_now() == saved_fl, "R12 flags kept", flags_now(), saved_fl);
    @(negedge clk);
    check(!done, "R11 done single cycle", done, 0);

    // R2/R11 loads and start ignored while busy
    load_dr(8'h03); load_mq(8'h05);
    @(negedge clk); start = 1'b1; opcode = OP_MUL;
    @(negedge clk); start = 1'b0;
    check(busy, "R11 busy after start", busy, 1);
    @(negedge clk);
    start = 1'b1; opcode = OP_ADD;
    dr_load = 1'b1; dr_wdata = 8'hFF; mq_load = 1'b1; mq_wdata = 8'hFF;
    @(negedge clk);
    start = 1'b0; dr_load = 1'b0; mq_load = 1'b0;
    n = 2;
    while (!done && n < 200) begin
      check(!(busy && done), "R11 busy/done exclusive", {busy, done}, 2'b10);
      @(negedge clk); n++;
    end
    check(n == W, "R11 run length with start while busy", n, W);
    check({ac_out, mq_out} == 16'h000F, "R2 R11 product unaffected", {ac_out, mq_out}, 16'h000F);
    run_op(OP_ADD, n);
    check(ac_out == 8'h03, "R2 dr load ignored while busy", ac_out, 8'h03);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule